// File: doc/BRIEF.md
# Readout Sync and Memory-Control Timing Generator

This block runs in the readout pixel clock domain of a line-doubling display path, independent of the write clock. A one-clock vertical reference pulse starts a pixel-position counter and a line counter. All timing on the readout side is derived from these two counters: the horizontal and vertical sync pulses, the horizontal and vertical blanking windows, the read-enable window for the field memory, and the one-clock and one-line clear strobes that rewind that memory.

Every pulse and window is placed by a static configuration word. The block compares the counters against these words and registers the results. The blanking windows only mark the screen border. They never gate the read enable, so the memory keeps streaming through the border regions. Configuration is expected to stay stable while the block runs. It is loaded while the block is held in reset or before the first reference pulse.

Top module: `rsg_readout_timing`

## Requirements
- R1: After reset and until the first `vref_i` pulse, every output is low and the counters hold.
- R2: A `vref_i` sampled high at a clock edge sets the position to pixel 0 of line 0. The pixel counter then advances once per clock. It returns to 0 after pixel `h_total_i`+1, so a line lasts `h_total_i`+2 clocks, and the line index advances at that point. Every output is registered and reflects the counter state one clock earlier. A later `vref_i` restarts the count at once.
- R3: `hsync_o` is high for pixels 0 to 67 of every line. When a line is shorter than 68 clocks, `hsync_o` is high for the whole line.
- R4: `hblank_o` is high for pixels p with `h_lblank_i`+2 <= p < `h_rblank_i`. If that range is empty, `hblank_o` stays low.
- R5: `rd_en_o` is high when both of these hold: the pixel p satisfies `h_start_i`+2 <= p, and the line L satisfies L >= `v_start_i`+1.
- R6: `hclr_o` is a one-clock pulse on every line, at pixel `h_start_i`+2.
- R7: `vsync_o` is high for 6 lines, starting at line 65 when `pal_mode_i` is 1 and at line 0 when it is 0.
- R8: `vblank_o` is high for lines L with `v_top_i`+1 <= L < 320+`v_bot_i`.
- R9: `vclr_o` is high for every pixel of line `v_start_i`, which is the line just before the vertical read window opens.
- R10: The blanking windows have no effect on `rd_en_o`. `rd_en_o` stays high inside `hblank_o` or `vblank_o` whenever R5 holds.
- R11: The line index saturates at 2^VW-1 (1023 by default) and holds there until the next `vref_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vref_i | input | 1 | Vertical reference pulse that starts or restarts the frame |
| pal_mode_i | input | 1 | 1 places the vertical sync 65 lines late |
| h_total_i | input | HW (11) | Readout dot count; line length is this value plus 2 clocks |
| h_start_i | input | HW (11) | Horizontal read-start value |
| h_lblank_i | input | HW (11) | Left blanking edge value |
| h_rblank_i | input | HW (11) | Right blanking edge, in clocks |
| v_start_i | input | VW (10) | Vertical read-start value |
| v_top_i | input | VW (10) | Top blanking value |
| v_bot_i | input | VW (10) | Bottom blanking value (added to 320) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking window |
| vblank_o | output | 1 | Vertical blanking window |
| rd_en_o | output | 1 | Field-memory read enable |
| hclr_o | output | 1 | Memory horizontal clear strobe |
| vclr_o | output | 1 | Memory vertical clear strobe |

## Verification
A `vref_i` sampled at one edge clears the counters at that edge. The outputs of position 0 appear after the following edge, so every output trails the counter state by exactly one clock. The bench keeps its own position and line model, which it steps once per clock in the same order. It drives inputs and samples outputs on the falling edge. At each falling edge it compares the outputs against the model state from before the rising edge that has just passed, and then advances the model with the `vref_i` value that edge sampled. Configuration changes only during reset, so no comparison depends on when a setting took effect.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned HSYNC_CLKS    = 68;
  localparam int unsigned VSYNC_LINES   = 6;
  localparam int unsigned PAL_VSYNC_OFS = 65;
  localparam int unsigned VBLANK_BASE   = 320;
  localparam int unsigned H_BIAS        = 2;
  localparam int unsigned V_BIAS        = 1;
  localparam int unsigned N_WIN         = 3;

  typedef struct packed {
    logic hsync;
    logic vsync;
    logic hblank;
    logic vblank;
    logic rd_en;
    logic hclr;
    logic vclr;
  } rsg_out_t;
endpackage

// File: rtl/rsg_window.sv
module rsg_window #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         in_o
);
  // inclusive start, exclusive end
  assign in_o = (pos_i >= lo_i) && (pos_i < hi_i);
endmodule

// File: rtl/rsg_hcount.sv
module rsg_hcount #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [CW-1:0] last_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q >= last_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rsg_vcount.sv
module rsg_vcount #(
  parameter int unsigned VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [VW-1:0] cnt_o
);
  logic [VW-1:0] cnt_q;

  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (step_i && (cnt_q != '1))   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rsg_readout_timing.sv
module rsg_readout_timing
  import rsg_pkg::*;
#(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vref_i,
  input  logic          pal_mode_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [HW-1:0] h_start_i,
  input  logic [HW-1:0] h_lblank_i,
  input  logic [HW-1:0] h_rblank_i,
  input  logic [VW-1:0] v_start_i,
  input  logic [VW-1:0] v_top_i,
  input  logic [VW-1:0] v_bot_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          rd_en_o,
  output logic          hclr_o,
  output logic          vclr_o
);
  localparam int unsigned HCW = HW + 1;
  localparam int unsigned HXW = HW + 2;
  localparam int unsigned VXW = VW + 2;

  logic           run_q;
  logic           adv;
  logic [HCW-1:0] hcnt;
  logic [VW-1:0]  vcnt;
  logic           hwrap;
  logic [HXW-1:0] h_pos;
  logic [VXW-1:0] v_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (vref_i) run_q <= 1'b1;
  end

  assign adv = run_q && !vref_i;

  rsg_hcount #(.CW(HCW)) u_hcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vref_i),
    .run_i  (adv),
    .last_i (HCW'(h_total_i) + HCW'(1)),
    .cnt_o  (hcnt),
    .wrap_o (hwrap)
  );

  rsg_vcount #(.VW(VW)) u_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vref_i),
    .step_i (hwrap),
    .cnt_o  (vcnt)
  );

  assign h_pos = HXW'(hcnt);
  assign v_pos = VXW'(vcnt);

  // window bounds: 0 sync, 1 blank, 2 read enable
  logic [HXW-1:0] h_lo [N_WIN];
  logic [HXW-1:0] h_hi [N_WIN];
  logic [VXW-1:0] v_lo [N_WIN];
  logic [VXW-1:0] v_hi [N_WIN];
  logic [N_WIN-1:0] h_in, v_in;
  logic [HXW-1:0] h_rd_lo;
  logic [VXW-1:0] v_sync_lo;

  assign h_rd_lo   = HXW'(h_start_i) + HXW'(H_BIAS);
  assign v_sync_lo = pal_mode_i ? VXW'(PAL_VSYNC_OFS) : '0;

  always_comb begin
    h_lo[0] = '0;
    h_hi[0] = HXW'(HSYNC_CLKS);
    h_lo[1] = HXW'(h_lblank_i) + HXW'(H_BIAS);
    h_hi[1] = HXW'(h_rblank_i);
    h_lo[2] = h_rd_lo;
    h_hi[2] = HXW'(h_total_i) + HXW'(H_BIAS);
    v_lo[0] = v_sync_lo;
    v_hi[0] = v_sync_lo + VXW'(VSYNC_LINES);
    v_lo[1] = VXW'(v_top_i) + VXW'(V_BIAS);
    v_hi[1] = VXW'(v_bot_i) + VXW'(VBLANK_BASE);
    v_lo[2] = VXW'(v_start_i) + VXW'(V_BIAS);
    v_hi[2] = '1;
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    rsg_window #(.W(HXW)) u_hwin (
      .pos_i (h_pos), .lo_i (h_lo[g]), .hi_i (h_hi[g]), .in_o (h_in[g])
    );
    rsg_window #(.W(VXW)) u_vwin (
      .pos_i (v_pos), .lo_i (v_lo[g]), .hi_i (v_hi[g]), .in_o (v_in[g])
    );
  end

  rsg_out_t nxt, out_q;

  always_comb begin
    nxt        = '0;
    nxt.hsync  = h_in[0];
    nxt.vsync  = v_in[0];
    nxt.hblank = h_in[1];
    nxt.vblank = v_in[1];
    nxt.rd_en  = h_in[2] && v_in[2];  // blanking deliberately not in this term
    nxt.hclr   = (h_pos == h_rd_lo);
    nxt.vclr   = (v_pos == VXW'(v_start_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    out_q <= '0;
    else if (run_q) out_q <= nxt;
    else            out_q <= '0;
  end

  assign hsync_o  = out_q.hsync;
  assign vsync_o  = out_q.vsync;
  assign hblank_o = out_q.hblank;
  assign vblank_o = out_q.vblank;
  assign rd_en_o  = out_q.rd_en;
  assign hclr_o   = out_q.hclr;
  assign vclr_o   = out_q.vclr;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic vref_i,
  input logic hsync_o,
  input logic vsync_o,
  input logic hblank_o,
  input logic vblank_o,
  input logic rd_en_o,
  input logic hclr_o,
  input logic vclr_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (vref_i) seen_q <= 1'b1;
  end

  AST_IDLE_BEFORE_VREF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !(hsync_o || vsync_o || hblank_o || vblank_o || rd_en_o || hclr_o || vclr_o))
    else $error("idle outputs active"); // R1

  AST_HCLR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclr_o |=> !hclr_o)
    else $error("hclr wider than one clock"); // R6

  AST_RDEN_RISE_HCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> hclr_o)
    else $error("read enable opened without clear"); // R5

  AST_VCLR_BEFORE_RDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vclr_o |-> !rd_en_o)
    else $error("vclr overlaps read window"); // R9

  AST_VSYNC_LINE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_o) |-> hsync_o)
    else $error("vsync moved off line start"); // R7

  AST_VBLANK_LINE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vblank_o) |-> hsync_o)
    else $error("vblank moved off line start"); // R8
endmodule

bind rsg_readout_timing rsg_checker u_rsg_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vref_i   (vref_i),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .hblank_o (hblank_o),
  .vblank_o (vblank_o),
  .rd_en_o  (rd_en_o),
  .hclr_o   (hclr_o),
  .vclr_o   (vclr_o)
);

// File: tb/tb_rsg_readout_timing.sv
module tb_rsg_readout_timing;
  localparam int HW = 11;
  localparam int VW = 10;
  localparam int LMAX = (1 << VW) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vref_i = 1'b0;
  logic pal_mode_i = 1'b0;
  logic [HW-1:0] h_total_i = '0, h_start_i = '0, h_lblank_i = '0, h_rblank_i = '0;
  logic [VW-1:0] v_start_i = '0, v_top_i = '0, v_bot_i = '0;
  logic hsync_o, vsync_o, hblank_o, vblank_o, rd_en_o, hclr_o, vclr_o;

  always #2 clk_i = ~clk_i;

  rsg_readout_timing #(.HW(HW), .VW(VW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .vref_i(vref_i), .pal_mode_i(pal_mode_i),
    .h_total_i(h_total_i), .h_start_i(h_start_i), .h_lblank_i(h_lblank_i),
    .h_rblank_i(h_rblank_i), .v_start_i(v_start_i), .v_top_i(v_top_i),
    .v_bot_i(v_bot_i), .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o),
    .vblank_o(vblank_o), .rd_en_o(rd_en_o), .hclr_o(hclr_o), .vclr_o(vclr_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int m_h = 0, m_l = 0;
  bit m_run = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (h=%0d line=%0d)", req, act, exp, m_h, m_l);
    end
  endtask

  // {hsync, vsync, hblank, vblank, rd_en, hclr, vclr}
  function automatic logic [6:0] exp_out();
    int h = m_h, l = m_l, ofs;
    logic hs, hb, he, hc, vs, vb, ve, vc;
    if (!m_run) return 7'b0;
    ofs = pal_mode_i ? 65 : 0;
    hs = h < 68;
    hb = (h >= int'(h_lblank_i) + 2) && (h < int'(h_rblank_i));
    he = (h >= int'(h_start_i) + 2) && (h < int'(h_total_i) + 2);
    hc = (h == int'(h_start_i) + 2);
    vs = (l >= ofs) && (l < ofs + 6);
    vb = (l >= int'(v_top_i) + 1) && (l < 320 + int'(v_bot_i));
    ve = (l >= int'(v_start_i) + 1);
    vc = (l == int'(v_start_i));
    return {hs, vs, hb, vb, he && ve, hc, vc};
  endfunction

  task automatic step();
    logic [6:0] e;
    @(negedge clk_i);
    if (done) return;
    e = exp_out();
    chk("R2/R3 hsync", hsync_o, e[6]);
    chk("R7 vsync", vsync_o, e[5]);
    chk("R4 hblank", hblank_o, e[4]);
    chk("R8/R11 vblank", vblank_o, e[3]);
    chk("R5/R10 rd_en", rd_en_o, e[2]);
    chk("R6 hclr", hclr_o, e[1]);
    chk("R9 vclr", vclr_o, e[0]);
    if (vref_i) begin
      m_run = 1; m_h = 0; m_l = 0;
    end else if (m_run) begin
      if (m_h >= int'(h_total_i) + 1) begin
        m_h = 0;
        if (m_l < LMAX) m_l++;
      end else m_h++;
    end
  endtask

  task automatic pulse_vref();
    vref_i = 1'b1;
    step();
    vref_i = 1'b0;
  endtask

  task automatic start(input int tot, hs, lb, rb, vs, top, bot, input bit pal);
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_run = 0; m_h = 0; m_l = 0;
    h_total_i = HW'(tot); h_start_i = HW'(hs); h_lblank_i = HW'(lb);
    h_rblank_i = HW'(rb); v_start_i = VW'(vs); v_top_i = VW'(top);
    v_bot_i = VW'(bot); pal_mode_i = pal;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: idle until the first reference pulse
    repeat (20) step();
    pulse_vref();
  endtask

  task automatic run(input int n, input int restart_at);
    for (int i = 0; i < n; i++) begin
      if (i == restart_at) pulse_vref();
      else step();
    end
  endtask

  initial begin
    void'($urandom(32'h5a17));
    // directed: line 100 clocks, vblank tail at line 340
    start(98, 20, 5, 90, 10, 3, 20, 1'b0);
    run(36000, -1);
    // random geometry with PAL offset and a restart mid-frame
    start($urandom_range(120, 70), $urandom_range(60, 0), $urandom_range(60, 0),
          $urandom_range(130, 0), $urandom_range(40, 0), $urandom_range(30, 0),
          $urandom_range(15, 0), 1'b1);
    run(40000, 15000);
    // corner: 12-clock line (R3 always high), empty hblank, read start on last pixel,
    // vblank ending exactly at the saturated line 1023 (R11)
    start(10, 9, 20, 5, 0, 0, 703, 1'b0);
    run(20000, -1);
    // random again, random mode
    start($urandom_range(120, 70), $urandom_range(80, 0), $urandom_range(80, 0),
          $urandom_range(130, 0), $urandom_range(60, 0), $urandom_range(40, 0),
          $urandom_range(30, 0), 1'($urandom_range(1, 0)));
    run(40000, 27000);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule